// File: doc/BRIEF.md
# NOR Flash Bus Front-End

This block models the bus side of a NOR-style flash part. The strobes chip-enable, output-enable, write-enable and address-valid are active low. The block samples them in one system clock domain and finds their edges. From those edges it latches the read address and accepts command bytes.

A small command decoder picks what a read returns: storage contents, a fixed identifier pair, or a status word. Reads from the main region go through a four-word page buffer. That buffer is refilled only when the page part of the latched address changes. Reads from the low parameter region go to the storage directly.

The data bus is given as a value plus an output enable, not as a tri-state pin. The storage is a small register array that the environment fills through a load port.

Top module: `flash_bus_frontend`

## Requirements
- R1: Reset puts the block in storage-read mode and empties the page buffer. `dout_oe` is 0 while `ce_n` is high after reset, and the first main-region read returns the stored word.
- R2: A command byte 0xFF selects storage reads, 0x90 selects identifier reads and 0x70 selects status reads. The new mode applies to every read that follows the command.
- R3: Any other command byte leaves the current read mode unchanged.
- R4: A write is armed when, at a clock edge, `ce_n`, `we_n` and `adv_n` are all low and `oe_n` is high. The command byte is taken from `din[7:0]` at the first later edge where `we_n` or `ce_n` is seen rising. A `we_n` rise that was never armed, for example with `oe_n` low, has no effect on the mode.
- R5: With `sync_rd` low, the address is captured at the clock edge where `adv_n` is first seen high after being low, provided `ce_n` was low. Later changes on `addr` while `adv_n` stays high do not change the data that is read.
- R6: With `sync_rd` high, the address is captured at the first clock edge where `adv_n` is low, `ce_n` is low and `we_n` is high. Address changes during the rest of that low phase, and the following `adv_n` rise, do not re-capture.
- R7: In identifier mode, word address 0 returns MFR_CODE (default 0x00A5), word address 1 returns DEV_CODE (default 0x0C31), and any other address returns 0.
- R8: In status mode, every read returns 0x0080. Bit 7 is the ready flag and is always 1.
- R9: Addresses at or above PARAM_WORDS are in the main region. Reads there come from a four-word page selected by address bits above bit 1, with bits 1:0 choosing the word. The page is refilled only when those upper bits differ from the buffered page, so a storage load into the buffered page stays invisible until another page has been read.
- R10: Addresses below PARAM_WORDS are in the parameter region. Reads there return the current storage word at once, including any load made since the last read.
- R11: With `oe_n` high, `dout_oe` is 0 and `dout` is 0.
- R12: With `ce_n` high, the block is in standby: `dout_oe` is 0 whatever `oe_n` is.
- R13: Read data is valid two clock edges after the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_rd | input | 1 | Chooses synchronous address capture |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| adv_n | input | 1 | Address valid, active low |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data bus (command byte in bits 7:0) |
| load_en | input | 1 | Storage load strobe |
| load_addr | input | ADDR_W | Storage load address |
| load_data | input | 16 | Storage load word |
| dout | output | 16 | Read data, 0 when not driven |
| dout_oe | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with ADDR_W = 6 and PARAM_WORDS = 16, which gives 64 words in 16 pages. This is small enough for a sweep that reads every address once. The sweep crosses both regions and forces a page refill at every fourth address.

The same small map lets the bench set up the stale-page case and the fresh parameter-region read directly. It also reaches the identifier words at 0 and 1 and both capture modes within a few hundred cycles.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  localparam int DATA_W = 16;

  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_STATUS = 8'h70;

  localparam logic [DATA_W-1:0] STATUS_READY = 16'h0080;

  typedef enum logic [1:0] {
    MD_ARRAY  = 2'd0,
    MD_IDENT  = 2'd1,
    MD_STATUS = 2'd2
  } mode_e;

  // Command decode: unknown bytes keep the current mode.
  function automatic mode_e fbf_next_mode(mode_e cur, logic [7:0] cmd);
    case (cmd)
      CMD_ARRAY:  return MD_ARRAY;
      CMD_IDENT:  return MD_IDENT;
      CMD_STATUS: return MD_STATUS;
      default:    return cur;
    endcase
  endfunction

  // Main region starts at the first word above the parameter region.
  function automatic logic fbf_is_main(int unsigned a, int unsigned param_words);
    return a >= param_words;
  endfunction

  function automatic logic [DATA_W-1:0] fbf_ident(int unsigned a,
                                                  logic [DATA_W-1:0] mfr,
                                                  logic [DATA_W-1:0] dev);
    case (a)
      0:       return mfr;
      1:       return dev;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/fbf_strobes.sv
module fbf_strobes #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_rd,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              we_rise,
  output logic              ce_rise,
  output logic [ADDR_W-1:0] addr_lat
);

  logic adv_d, we_d, ce_d, lat_done;
  logic adv_rise, sync_grab, rise_grab, addr_grab;

  assign adv_rise = adv_n & ~adv_d;
  assign we_rise  = we_n & ~we_d;
  assign ce_rise  = ce_n & ~ce_d;

  // Synchronous capture: first edge with address-valid low and no write.
  assign sync_grab = ~ce_n & ~adv_n & we_n & ~lat_done;
  assign rise_grab = adv_rise & ~ce_d;
  assign addr_grab = sync_rd ? (sync_grab | (rise_grab & ~lat_done)) : rise_grab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_d    <= 1'b1;
      we_d     <= 1'b1;
      ce_d     <= 1'b1;
      lat_done <= 1'b0;
      addr_lat <= '0;
    end else begin
      adv_d <= adv_n;
      we_d  <= we_n;
      ce_d  <= ce_n;
      if (adv_n)          lat_done <= 1'b0;
      else if (addr_grab) lat_done <= 1'b1;
      if (addr_grab) addr_lat <= addr;
    end
  end

  a_r5_async_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_rd && adv_n && !adv_d && !ce_d) |=> addr_lat == $past(addr));

  a_r6_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rd && !adv_n && lat_done) |=> addr_lat == $past(addr_lat));

endmodule

// File: rtl/fbf_cui.sv
module fbf_cui
  import fbf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       adv_n,
  input  logic       we_rise,
  input  logic       ce_rise,
  input  logic [7:0] cmd,
  output mode_e      mode
);

  logic wr_arm, cmd_fire, wr_cond;

  assign wr_cond  = ~ce_n & ~we_n & ~adv_n & oe_n;
  assign cmd_fire = wr_arm & (we_rise | ce_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_arm <= 1'b0;
      mode   <= MD_ARRAY;
    end else begin
      if (cmd_fire)     wr_arm <= 1'b0;
      else if (wr_cond) wr_arm <= 1'b1;
      if (cmd_fire) mode <= fbf_next_mode(mode, cmd);
    end
  end

  a_r1_reset_mode: assert property (@(posedge clk)
    !rst_n |=> mode == MD_ARRAY);

  a_r2_ident_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd == CMD_IDENT) |=> mode == MD_IDENT);

  a_r3_unknown_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd != CMD_ARRAY && cmd != CMD_IDENT && cmd != CMD_STATUS)
    |=> $stable(mode));

  a_r4_unarmed_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_arm) |=> $stable(mode));

endmodule

// File: rtl/fbf_page.sv
module fbf_page
  import fbf_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int PARAM_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic [ADDR_W-1:0] addr_lat,
  input  logic              array_mode,
  output logic              rd_main,
  output logic [DATA_W-1:0] page_word,
  output logic [DATA_W-1:0] param_word
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int TAG_W   = ADDR_W - 2;
  localparam int PG_WORDS = 4;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] pg_data [PG_WORDS];
  logic [TAG_W-1:0]  pg_tag;
  logic              pg_valid;
  logic              pg_fill;
  logic [TAG_W-1:0]  req_tag;

  assign req_tag = addr_lat[ADDR_W-1:2];
  assign rd_main = fbf_is_main(32'(addr_lat), PARAM_WORDS);
  assign pg_fill = array_mode & rd_main & (~pg_valid | (pg_tag != req_tag));

  always_ff @(posedge clk) begin
    if (load_en) store[load_addr] <= load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_valid <= 1'b0;
      pg_tag   <= '0;
    end else if (pg_fill) begin
      pg_valid <= 1'b1;
      pg_tag   <= req_tag;
    end
  end

  for (genvar i = 0; i < PG_WORDS; i++) begin : g_page
    always_ff @(posedge clk) begin
      if (pg_fill) pg_data[i] <= store[{req_tag, 2'(i)}];
    end
  end

  assign page_word  = pg_data[addr_lat[1:0]];
  assign param_word = store[addr_lat];

  a_r9_fill_tag: assert property (@(posedge clk) disable iff (!rst_n)
    pg_fill |=> (pg_valid && pg_tag == $past(req_tag)));

endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
  import fbf_pkg::*;
#(
  parameter int          ADDR_W      = 6,
  parameter int          PARAM_WORDS = 16,
  parameter logic [15:0] MFR_CODE    = 16'h00A5,
  parameter logic [15:0] DEV_CODE    = 16'h0C31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_rd,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [15:0]       load_data,
  output logic [15:0]       dout,
  output logic              dout_oe
);

  logic              we_rise, ce_rise, rd_main;
  logic [ADDR_W-1:0] addr_lat;
  logic [DATA_W-1:0] page_word, param_word, rd_word;
  mode_e             mode;

  fbf_strobes #(.ADDR_W(ADDR_W)) u_strobes (
    .clk(clk), .rst_n(rst_n), .sync_rd(sync_rd), .ce_n(ce_n), .we_n(we_n),
    .adv_n(adv_n), .addr(addr), .we_rise(we_rise), .ce_rise(ce_rise),
    .addr_lat(addr_lat)
  );

  fbf_cui u_cui (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .adv_n(adv_n), .we_rise(we_rise), .ce_rise(ce_rise), .cmd(din[7:0]),
    .mode(mode)
  );

  fbf_page #(.ADDR_W(ADDR_W), .PARAM_WORDS(PARAM_WORDS)) u_page (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .addr_lat(addr_lat), .array_mode(mode == MD_ARRAY),
    .rd_main(rd_main), .page_word(page_word), .param_word(param_word)
  );

  always_comb begin
    case (mode)
      MD_IDENT:  rd_word = fbf_ident(32'(addr_lat), MFR_CODE, DEV_CODE);
      MD_STATUS: rd_word = STATUS_READY;
      default:   rd_word = rd_main ? page_word : param_word;
    endcase
  end

  assign dout_oe = ~ce_n & ~oe_n;
  assign dout    = dout_oe ? rd_word : '0;

  a_r11_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == '0);

  a_r12_standby: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_oe);

  a_r8_status_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_STATUS && dout_oe) |-> dout == 16'h0080);

endmodule

// File: tb/flash_bus_frontend_test.sv
module flash_bus_frontend_test;

  localparam int AW = 6;
  localparam int PW = 16;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync_rd = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, adv_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   din = '0;
  logic          load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [15:0]   load_data = '0;
  logic [15:0]   dout;
  logic          dout_oe;

  int checks = 0;
  int errors = 0;
  logic [15:0] shadow [NW];

  always #10 clk = ~clk;

  flash_bus_frontend #(.ADDR_W(AW), .PARAM_WORDS(PW)) uut (
    .clk(clk), .rst_n(rst_n), .sync_rd(sync_rd), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .adv_n(adv_n), .addr(addr), .din(din), .load_en(load_en),
    .load_addr(load_addr), .load_data(load_data), .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [15:0] pat(int a, int salt);
    return 16'((a * 263 + salt * 4099) ^ 16'hA55A);
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load(int a, logic [15:0] d);
    @(negedge clk);
    load_en = 1'b1; load_addr = AW'(a); load_data = d;
    @(negedge clk);
    load_en = 1'b0;
    shadow[a] = d;
  endtask

  task automatic write_cmd(logic [7:0] c, logic oe_val);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; adv_n = 1'b0; oe_n = oe_val; din = {8'h00, c};
    @(negedge clk);
    adv_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic latch_async(int a);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; adv_n = 1'b0; addr = AW'(a);
    @(negedge clk);
    adv_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sample(output logic [15:0] d, output logic e);
    @(negedge clk);
    oe_n = 1'b0;
    #2;
    d = dout; e = dout_oe;
    oe_n = 1'b1;
  endtask

  task automatic read_chk(string req, int a, logic [15:0] exp);
    logic [15:0] d;
    logic e;
    latch_async(a);
    sample(d, e);
    chk(req, d, exp);
    chk(req, 16'(e), 16'h1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    logic e;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset oe", 16'(dout_oe), 16'h0);
    chk("R11 reset dout", dout, 16'h0);
    rst_n = 1'b1;

    for (int a = 0; a < NW; a++) load(a, pat(a, 0));

    // R1: first main read after reset is served from storage
    read_chk("R1", 40, shadow[40]);

    // R9 R10 R13: sweep every word, crossing regions and pages
    for (int a = 0; a < NW; a++)
      read_chk(a < PW ? "R10 sweep" : "R9 sweep", a, shadow[a]);

    // R9: stale page until another page is read
    read_chk("R9", 33, shadow[33]);
    begin
      logic [15:0] old34;
      old34 = shadow[34];
      load(34, pat(34, 7));
      read_chk("R9 stale", 34, old34);
    end
    read_chk("R9 other page", 40, shadow[40]);
    read_chk("R9 refill", 34, shadow[34]);

    // R10: parameter region sees a fresh load
    read_chk("R10", 5, shadow[5]);
    load(5, pat(5, 9));
    read_chk("R10 fresh", 5, shadow[5]);

    // R5: address change after capture ignored
    latch_async(44);
    @(negedge clk); addr = AW'(50);
    repeat (3) @(negedge clk);
    sample(d, e);
    chk("R5", d, shadow[44]);

    // R6: synchronous capture
    sync_rd = 1'b1;
    @(negedge clk);
    ce_n = 1'b0; adv_n = 1'b0; addr = AW'(20);
    @(negedge clk); addr = AW'(52);
    @(negedge clk); adv_n = 1'b1;
    repeat (3) @(negedge clk);
    sample(d, e);
    chk("R6", d, shadow[20]);
    sync_rd = 1'b0;

    // R11 R12
    latch_async(44);
    #2;
    chk("R11 oe high", 16'(dout_oe), 16'h0);
    chk("R11 dout zero", dout, 16'h0);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
    #2;
    chk("R12 standby", 16'(dout_oe), 16'h0);
    chk("R12 dout zero", dout, 16'h0);
    @(negedge clk); oe_n = 1'b1;

    // R4: unarmed rise (oe low) does nothing
    write_cmd(8'h90, 1'b0);
    read_chk("R4", 1, shadow[1]);

    // R2 R7: identifier reads
    write_cmd(8'h90, 1'b1);
    read_chk("R7 mfr", 0, 16'h00A5);
    read_chk("R7 dev", 1, 16'h0C31);
    read_chk("R7 other", 2, 16'h0000);
    read_chk("R7 main", 40, 16'h0000);

    // R3: unknown byte keeps identifier mode
    write_cmd(8'h42, 1'b1);
    read_chk("R3", 1, 16'h0C31);

    // R8: status
    write_cmd(8'h70, 1'b1);
    read_chk("R8", 7, 16'h0080);
    read_chk("R8", 45, 16'h0080);
    write_cmd(8'h00, 1'b1);
    read_chk("R3 status kept", 3, 16'h0080);

    // R2: back to storage reads
    write_cmd(8'hFF, 1'b1);
    read_chk("R2", 40, shadow[40]);
    read_chk("R2", 9, shadow[9]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule